// File: doc/BRIEF.md
# Two-Way Write-Through Cache Controller

This block is an 8 KB unified instruction and data cache for a 32-bit processor. It is built as two ways of 4 KB, and each line holds four 32-bit words. A read that misses fetches the whole line from a simple single-word memory port. The fetch starts with the word that was requested and wraps around inside the line. The processor gets its data as soon as that first word arrives.

Every store is written through to memory. A store that hits also updates the cached copy. A store that misses does not allocate a line. Each set has one 2-bit status field that records both which ways are valid and which way is the next victim, which gives a pseudo-LRU policy.

Any access with address bit 26 set bypasses the cache. Software can rewrite any tag entry, and writing zero into its status bits invalidates the set. A mode input gives half or all of the storage to a directly addressed internal SRAM.

Top module: `wt_cache`

## Requirements
- R1: After reset every set status is 00 (no way valid) and cpu_ack and mem_req are low, so the first read of any line misses.
- R2: A cacheable read that hits returns the word with a one-cycle cpu_ack pulse in the cycle after the request is accepted, and makes no memory access.
- R3: A cacheable read that misses makes four single-word memory reads. The first read is at the requested word, and the word index then increments modulo 4 inside the 16-byte line. cpu_ack rises one cycle after the requested word's mem_ack, and the remaining reads follow.
- R4: Every write outside the SRAM window makes exactly one memory write with the same word address and data, and cpu_ack rises one cycle after its mem_ack. A write hit also updates the cached word. A write miss allocates nothing.
- R5: An access with address bit 26 = 1 bypasses the cache. A read makes a single memory read and fills nothing.
- R6: With cache_en = 0, every read is a single memory read, with no lookup and no fill.
- R7: The set status encodes 00 = none valid, 01 = only way 0 valid, 10 = both valid with victim way 0, 11 = both valid with victim way 1. A fill goes to way 0 from 00, to way 1 from 01, and to the victim otherwise. Any hit or fill makes the other way the victim.
- R8: A tag write stores tag_wr_data[31:30] as the set status and tag_wr_data[14:0] as the tag of the chosen way. Writing 00 to the status invalidates the set, and a forged valid entry is then hit.
- R9: cache_mode 00 uses both ways as cache. Mode 01 caches in way 0 only (direct mapped, status never above 01) and gives way 1 as a 4 KB SRAM. Mode 1x gives 8 KB of SRAM, with address bit 12 selecting the way, and caches nothing. Software must clear the tags after changing the mode.
- R10: Accesses whose address bits [31:13] equal those of SRAM_BASE (0x1000_0000) while the mode is not 00 read or write the SRAM. The ack comes one cycle later and there is no memory traffic.
- R11: mem_req, once raised, holds its address, direction and data stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Lookup enable; 0 sends every access to memory |
| cache_mode | input | 2 | 00 full cache, 01 half cache and half SRAM, 1x all SRAM |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | 1 = write |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| cpu_ack | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory completion pulse |
| tag_wr | input | 1 | Software tag-entry write strobe |
| tag_wr_set | input | 8 | Set index of the tag write |
| tag_wr_way | input | 1 | Way of the tag write |
| tag_wr_data | input | 32 | Entry: [31:30] status, [14:0] tag |

## Verification
The timing depends on the kind of access:

- **Hit or SRAM access:** the ack is due exactly one cycle after the request is taken.
- **Memory access (fill, bypass read or write):** the ack is due one cycle after the mem_ack of the word that completes it. For a fill, that word is the first beat.

The bench therefore samples on falling edges. It counts the cycles from request to ack and the cycles from the last observed mem_ack to the ack, and compares them against these figures. It keeps watching the memory port after the ack until mem_req falls. This lets it record the address order of all four fill beats, and confirm that no traffic follows a hit.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_FILL = 2'd1,
        S_RD   = 2'd2,
        S_WR   = 2'd3
    } ctl_state_e;

    // per-set status: validity and replacement in one field
    localparam logic [1:0] ST_NONE  = 2'b00;
    localparam logic [1:0] ST_W0    = 2'b01;
    localparam logic [1:0] ST_VIC0  = 2'b10;
    localparam logic [1:0] ST_VIC1  = 2'b11;

    function automatic logic pick_victim(input logic [1:0] st, input logic two_way);
        if (!two_way)          return 1'b0;
        else if (st == ST_NONE) return 1'b0;
        else if (st == ST_W0)   return 1'b1;
        else                    return st[0];
    endfunction

    function automatic logic [1:0] touch_status(input logic [1:0] st, input logic way,
                                                input logic two_way);
        if (!two_way)                          return ST_W0;
        else if (st == ST_NONE || st == ST_W0) return way ? ST_VIC0 : ST_W0;
        else                                   return way ? ST_VIC0 : ST_VIC1;
    endfunction

endpackage

// File: rtl/wtc_tags.sv
module wtc_tags #(
    parameter int SETS  = 256,
    parameter int IDX_W = 8,
    parameter int TAG_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_set,
    output logic [TAG_W-1:0] lk_tag0,
    output logic [TAG_W-1:0] lk_tag1,
    output logic [1:0]       lk_st,
    input  logic [IDX_W-1:0] hw_set,
    input  logic             hw_st_we,
    input  logic [1:0]       hw_st,
    input  logic             hw_tag_we,
    input  logic             hw_way,
    input  logic [TAG_W-1:0] hw_tag,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_set,
    input  logic             sw_way,
    input  logic [31:0]      sw_entry
);
    logic [TAG_W-1:0] tag_q [2][SETS];
    logic [1:0]       st_q  [SETS];

    assign lk_tag0 = tag_q[0][lk_set];
    assign lk_tag1 = tag_q[1][lk_set];
    assign lk_st   = st_q[lk_set];

    // status is cleared by reset; a software write is overridden by a same-cycle hardware one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) st_q[i] <= 2'b00;
        end else begin
            if (sw_we)    st_q[sw_set] <= sw_entry[31:30];
            if (hw_st_we) st_q[hw_set] <= hw_st;
        end
    end

    always_ff @(posedge clk) begin
        if (sw_we)     tag_q[sw_way][sw_set] <= sw_entry[TAG_W-1:0];
        if (hw_tag_we) tag_q[hw_way][hw_set] <= hw_tag;
    end
endmodule

// File: rtl/wtc_data.sv
module wtc_data #(
    parameter int DW    = 32,
    parameter int DEPTH = 1024,
    parameter int AIDX  = 10
) (
    input  logic                clk,
    input  logic [AIDX-1:0]     rd_idx,
    output logic [1:0][DW-1:0]  rdata,
    input  logic                we,
    input  logic                wr_way,
    input  logic [AIDX-1:0]     wr_idx,
    input  logic [DW-1:0]       wdata
);
    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [DW-1:0] arr [DEPTH];
        always_ff @(posedge clk) begin
            if (we && (wr_way == 1'(w))) arr[wr_idx] <= wdata;
        end
        assign rdata[w] = arr[rd_idx];
    end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter int          IDX_W     = 8,
    parameter int          WORD_W    = 2,
    parameter int          BYTE_W    = 2,
    parameter int          TAG_W     = 15,
    parameter int          NC_BIT    = 26,
    parameter logic [31:0] SRAM_BASE = 32'h1000_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cache_en,
    input  logic [1:0]              cache_mode,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [AW-1:0]           cpu_addr,
    input  logic [DW-1:0]           cpu_wdata,
    output logic [DW-1:0]           cpu_rdata,
    output logic                    cpu_ack,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [DW-1:0]           mem_wdata,
    input  logic [DW-1:0]           mem_rdata,
    input  logic                    mem_ack,
    output logic [IDX_W-1:0]        lk_set,
    input  logic [TAG_W-1:0]        lk_tag0,
    input  logic [TAG_W-1:0]        lk_tag1,
    input  logic [1:0]              lk_st,
    output logic                    hw_st_we,
    output logic [1:0]              hw_st,
    output logic                    hw_tag_we,
    output logic                    hw_way,
    output logic [TAG_W-1:0]        hw_tag,
    output logic [IDX_W+WORD_W-1:0] d_rd_idx,
    input  logic [1:0][DW-1:0]      d_rdata,
    output logic                    d_we,
    output logic                    d_way,
    output logic [IDX_W+WORD_W-1:0] d_wr_idx,
    output logic [DW-1:0]           d_wdata
);
    localparam int OFS_W   = WORD_W + BYTE_W;
    localparam int TAG_LSB = OFS_W + IDX_W;
    localparam int WIN_LSB = TAG_LSB + 1;

    typedef struct packed {
        ctl_state_e         state;
        logic               ack;
        logic [DW-1:0]      rdata;
        logic               mreq;
        logic               mwe;
        logic [AW-1:0]      maddr;
        logic [DW-1:0]      mwdata;
        logic [AW-1:0]      addr;
        logic               way;
        logic [WORD_W-1:0]  beat;
    } ctl_t;

    ctl_t q, d;

    logic [AW-1:0]    a;
    logic [TAG_W-1:0] a_tag;
    logic             two_way, in_win, sram, sram_way, cacheable;
    logic             hit0, hit1, hit;

    assign a         = (q.state == S_IDLE) ? cpu_addr : q.addr;
    assign a_tag     = a[TAG_LSB+TAG_W-1:TAG_LSB];
    assign lk_set    = a[TAG_LSB-1:OFS_W];
    assign d_rd_idx  = a[TAG_LSB-1:BYTE_W];
    assign two_way   = (cache_mode == 2'b00);
    assign in_win    = (a[AW-1:WIN_LSB] == SRAM_BASE[AW-1:WIN_LSB]);
    assign sram      = (cache_mode != 2'b00) && in_win;
    assign sram_way  = cache_mode[1] ? a[TAG_LSB] : 1'b1;
    assign cacheable = cache_en && !cache_mode[1] && !a[NC_BIT] && !sram;
    assign hit0      = cacheable && (lk_st != ST_NONE) && (lk_tag0 == a_tag);
    assign hit1      = cacheable && two_way && lk_st[1] && (lk_tag1 == a_tag);
    assign hit       = hit0 || hit1;

    always_comb begin
        d         = q;
        d.ack     = 1'b0;
        d_we      = 1'b0;
        d_way     = 1'b0;
        d_wr_idx  = a[TAG_LSB-1:BYTE_W];
        d_wdata   = cpu_wdata;
        hw_st_we  = 1'b0;
        hw_st     = lk_st;
        hw_tag_we = 1'b0;
        hw_way    = q.way;
        hw_tag    = a_tag;

        unique case (q.state)
            S_IDLE: begin
                if (cpu_req && !q.ack) begin
                    d.addr = cpu_addr;
                    if (sram) begin
                        d.ack = 1'b1;
                        if (cpu_we) begin
                            d_we  = 1'b1;
                            d_way = sram_way;
                        end else begin
                            d.rdata = d_rdata[sram_way];
                        end
                    end else if (cpu_we) begin
                        if (hit) begin
                            d_we     = 1'b1;
                            d_way    = hit1;
                            hw_st_we = 1'b1;
                            hw_st    = touch_status(lk_st, hit1, two_way);
                        end
                        d.state  = S_WR;
                        d.mreq   = 1'b1;
                        d.mwe    = 1'b1;
                        d.maddr  = {cpu_addr[AW-1:BYTE_W], BYTE_W'(0)};
                        d.mwdata = cpu_wdata;
                    end else if (hit) begin
                        d.ack    = 1'b1;
                        d.rdata  = d_rdata[hit1];
                        hw_st_we = 1'b1;
                        hw_st    = touch_status(lk_st, hit1, two_way);
                    end else begin
                        d.state = cacheable ? S_FILL : S_RD;
                        d.way   = pick_victim(lk_st, two_way);
                        d.beat  = '0;
                        d.mreq  = 1'b1;
                        d.mwe   = 1'b0;
                        d.maddr = {cpu_addr[AW-1:BYTE_W], BYTE_W'(0)};
                    end
                end
            end
            S_FILL: begin
                if (mem_ack) begin
                    d_we     = 1'b1;
                    d_way    = q.way;
                    d_wr_idx = {a[TAG_LSB-1:OFS_W], q.maddr[OFS_W-1:BYTE_W]};
                    d_wdata  = mem_rdata;
                    if (q.beat == '0) begin
                        d.ack   = 1'b1;
                        d.rdata = mem_rdata;
                    end
                    d.beat = q.beat + 1'b1;
                    if (q.beat == '1) begin
                        d.mreq    = 1'b0;
                        d.state   = S_IDLE;
                        hw_tag_we = 1'b1;
                        hw_st_we  = 1'b1;
                        hw_st     = touch_status(lk_st, q.way, two_way);
                    end else begin
                        d.maddr = {q.maddr[AW-1:OFS_W],
                                   q.maddr[OFS_W-1:BYTE_W] + WORD_W'(1),
                                   BYTE_W'(0)};
                    end
                end
            end
            S_RD: begin
                if (mem_ack) begin
                    d.mreq  = 1'b0;
                    d.ack   = 1'b1;
                    d.rdata = mem_rdata;
                    d.state = S_IDLE;
                end
            end
            S_WR: begin
                if (mem_ack) begin
                    d.mreq  = 1'b0;
                    d.ack   = 1'b1;
                    d.state = S_IDLE;
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: S_IDLE, default: '0};
        else        q <= d;
    end

    assign cpu_ack   = q.ack;
    assign cpu_rdata = q.rdata;
    assign mem_req   = q.mreq;
    assign mem_we    = q.mwe;
    assign mem_addr  = q.maddr;
    assign mem_wdata = q.mwdata;
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
    parameter int          AW         = 32,
    parameter int          DW         = 32,
    parameter int          WAY_BYTES  = 4096,
    parameter int          LINE_WORDS = 4,
    parameter int          TAG_W      = 15,
    parameter int          NC_BIT     = 26,
    parameter logic [31:0] SRAM_BASE  = 32'h1000_0000,
    localparam int         BYTE_W     = $clog2(DW / 8),
    localparam int         WORD_W     = $clog2(LINE_WORDS),
    localparam int         OFS_W      = WORD_W + BYTE_W,
    localparam int         SETS       = WAY_BYTES / (LINE_WORDS * (DW / 8)),
    localparam int         IDX_W      = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic [1:0]        cache_mode,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic              cpu_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ack,
    input  logic              tag_wr,
    input  logic [IDX_W-1:0]  tag_wr_set,
    input  logic              tag_wr_way,
    input  logic [31:0]       tag_wr_data
);
    localparam int AIDX = IDX_W + WORD_W;

    logic [IDX_W-1:0] lk_set;
    logic [TAG_W-1:0] lk_tag0, lk_tag1, hw_tag;
    logic [1:0]       lk_st, hw_st;
    logic             hw_st_we, hw_tag_we, hw_way;
    logic [AIDX-1:0]  d_rd_idx, d_wr_idx;
    logic [1:0][DW-1:0] d_rdata;
    logic             d_we, d_way;
    logic [DW-1:0]    d_wdata;

    wtc_ctrl #(
        .AW(AW), .DW(DW), .IDX_W(IDX_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W),
        .TAG_W(TAG_W), .NC_BIT(NC_BIT), .SRAM_BASE(SRAM_BASE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .cache_mode(cache_mode),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .lk_set(lk_set), .lk_tag0(lk_tag0), .lk_tag1(lk_tag1), .lk_st(lk_st),
        .hw_st_we(hw_st_we), .hw_st(hw_st), .hw_tag_we(hw_tag_we), .hw_way(hw_way),
        .hw_tag(hw_tag),
        .d_rd_idx(d_rd_idx), .d_rdata(d_rdata), .d_we(d_we), .d_way(d_way),
        .d_wr_idx(d_wr_idx), .d_wdata(d_wdata)
    );

    wtc_tags #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_set(lk_set), .lk_tag0(lk_tag0), .lk_tag1(lk_tag1), .lk_st(lk_st),
        .hw_set(lk_set), .hw_st_we(hw_st_we), .hw_st(hw_st),
        .hw_tag_we(hw_tag_we), .hw_way(hw_way), .hw_tag(hw_tag),
        .sw_we(tag_wr), .sw_set(tag_wr_set), .sw_way(tag_wr_way), .sw_entry(tag_wr_data)
    );

    wtc_data #(.DW(DW), .DEPTH(SETS * LINE_WORDS), .AIDX(AIDX)) u_data (
        .clk(clk), .rd_idx(d_rd_idx), .rdata(d_rdata),
        .we(d_we), .wr_way(d_way), .wr_idx(d_wr_idx), .wdata(d_wdata)
    );
endmodule

// File: rtl/wtc_chk.sv
module wtc_chk #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int OFS_W = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cache_mode,
    input logic          cpu_req,
    input logic          cpu_ack,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack,
    input logic          hw_st_we,
    input logic [1:0]    hw_st
);
    // R2: completion is a single-cycle pulse
    a_r2_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R2: an ack only answers a request that was present at the accepting edge
    a_r2_ack_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> $past(cpu_req));

    // R11: memory request held stable until acknowledged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R3: a read beat that follows an acknowledged read beat stays inside the line
    a_r3_fill_same_line: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && $past(mem_req && mem_ack && !mem_we))
            |-> (mem_addr[AW-1:OFS_W] == $past(mem_addr[AW-1:OFS_W])));

    // R9: in half-cache mode the status never records way 1 as valid
    a_r9_oneway_status: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_mode == 2'b01 && hw_st_we) |-> (hw_st == 2'b01));
endmodule

bind wt_cache wtc_chk #(.AW(AW), .DW(DW), .OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cache_mode(cache_mode),
    .cpu_req(cpu_req), .cpu_ack(cpu_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .hw_st_we(hw_st_we), .hw_st(hw_st)
);

// File: tb/sim_wt_cache.sv
module sim_wt_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b1;
    logic [1:0]  cache_mode = 2'b00;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ack;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        tag_wr = 1'b0;
    logic [7:0]  tag_wr_set = '0;
    logic        tag_wr_way = 1'b0;
    logic [31:0] tag_wr_data = '0;

    int nchk = 0, nfail = 0, cyc = 0, wait_c = 0;

    always #2 clk = ~clk;

    wt_cache u0 (.*);

    // memory model
    logic [31:0] memory [logic [31:0]];
    logic [31:0] sram_m [logic [31:0]];

    function automatic logic [31:0] memv(input logic [31:0] a);
        if (memory.exists(a)) return memory[a];
        return {a[15:0], ~a[15:0]} ^ 32'h1234_5678;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wait_c  <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            wait_c  <= $urandom_range(0, 3);
        end else if (mem_req) begin
            if (wait_c == 0) begin
                mem_ack <= 1'b1;
                if (mem_we) memory[mem_addr] = mem_wdata;
                else        mem_rdata <= memv(mem_addr);
            end else begin
                wait_c <= wait_c - 1;
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            summary();
        end
    end

    task automatic chkeq(input string r, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    // reference model of tags and status
    logic [14:0] mt [2][256];
    logic [1:0]  ms [256];

    task automatic model_clear();
        for (int s = 0; s < 256; s++) begin
            ms[s] = 2'b00; mt[0][s] = '0; mt[1][s] = '0;
        end
    endtask

    function automatic logic m_victim(input logic [1:0] st, input logic tw);
        if (!tw || st == 2'b00) return 1'b0;
        if (st == 2'b01) return 1'b1;
        return st == 2'b11;
    endfunction

    function automatic logic [1:0] m_next(input logic [1:0] st, input logic w, input logic tw);
        if (!tw) return 2'b01;
        if (st[1] == 1'b0) return w ? 2'b10 : 2'b01;
        return w ? 2'b10 : 2'b11;
    endfunction

    function automatic logic in_sram(input logic [31:0] a);
        return cache_mode != 2'b00 && a[31:13] == 19'h08000;
    endfunction

    function automatic logic [31:0] sram_key(input logic [31:0] a);
        logic w = cache_mode[1] ? a[12] : 1'b1;
        return {21'd0, w, a[11:2]};
    endfunction

    task automatic model(input logic we, input logic [31:0] a, output int e_rd, output int e_wr);
        logic [7:0] s = a[11:4];
        logic [14:0] tg = a[26:12];
        logic tw = (cache_mode == 2'b00);
        logic cach = cache_en && !cache_mode[1] && !a[26];
        logic [1:0] st = ms[s];
        logic h0 = cach && st != 2'b00 && mt[0][s] == tg;
        logic h1 = cach && tw && st[1] && mt[1][s] == tg;
        logic v;
        e_rd = 0; e_wr = 0;
        if (in_sram(a)) return;
        if (we) begin
            e_wr = 1;
            if (h0 || h1) ms[s] = m_next(st, h1, tw);
        end else if (h0 || h1) begin
            ms[s] = m_next(st, h1, tw);
        end else if (cach) begin
            e_rd = 4;
            v = m_victim(st, tw);
            mt[v][s] = tg;
            ms[s] = m_next(st, v, tw);
        end else begin
            e_rd = 1;
        end
    endtask

    // one processor access, watching the memory port until it falls idle
    task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] wd,
                       output logic [31:0] rd, output int nrd, output int nwr,
                       output int lat, output int gap, output logic [31:0] ra [4],
                       output logic [31:0] wa, output logic [31:0] wdat);
        int last = 0;
        logic got = 1'b0;
        nrd = 0; nwr = 0; lat = 0; gap = -1; wa = '0; wdat = '0; rd = '0;
        for (int k = 0; k < 4; k++) ra[k] = '0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        while (!got || mem_req) begin
            @(negedge clk);
            if (!got) lat++;
            if (mem_ack) begin
                last = lat;
                if (mem_we) begin nwr++; wa = mem_addr; wdat = mem_wdata; end
                else begin if (nrd < 4) ra[nrd] = mem_addr; nrd++; end
            end
            if (cpu_ack && !got) begin
                got = 1'b1; rd = cpu_rdata; cpu_req = 1'b0;
                if (last != 0) gap = lat - last;
            end
        end
    endtask

    task automatic run(input string r, input logic we, input logic [31:0] a,
                       input logic [31:0] wd, input logic ckdata);
        int e_rd, e_wr, nrd, nwr, lat, gap;
        logic [31:0] rd, wa, wdat, exp;
        logic [31:0] ra [4];
        logic srm = in_sram(a);
        exp = srm ? (sram_m.exists(sram_key(a)) ? sram_m[sram_key(a)] : 32'h0) : memv(a);
        model(we, a, e_rd, e_wr);
        acc(we, a, wd, rd, nrd, nwr, lat, gap, ra, wa, wdat);
        chkeq(r, "memory reads", nrd, e_rd);
        chkeq(r, "memory writes", nwr, e_wr);
        if (!we && ckdata) chkeq(r, "read data", rd, exp);
        if (e_rd == 0 && e_wr == 0) chkeq(r, "ack latency", lat, 1);
        else chkeq(r, "ack after beat", gap, 1);
        if (we && !srm) begin
            chkeq(r, "write address", wa, {a[31:2], 2'b00});
            chkeq(r, "write data / memory", memv({a[31:2], 2'b00}), wd);
        end
        if (we && srm) sram_m[sram_key(a)] = wd;
        if (e_rd == 4)
            for (int k = 0; k < 4; k++)
                chkeq(r, "fill beat order", ra[k], {a[31:4], 2'(a[3:2] + 2'(k)), 2'b00});
    endtask

    task automatic tag_write(input logic [7:0] s, input logic w, input logic [31:0] e);
        @(negedge clk);
        tag_wr = 1'b1; tag_wr_set = s; tag_wr_way = w; tag_wr_data = e;
        @(negedge clk);
        tag_wr = 1'b0;
        ms[s] = e[31:30]; mt[w][s] = e[14:0];
    endtask

    task automatic clear_tags();
        for (int s = 0; s < 256; s++) tag_write(8'(s), 1'b0, 32'h0);
        model_clear();
    endtask

    initial begin
        void'($urandom(32'h5EED));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chkeq("R1", "cpu_ack after reset", cpu_ack, 0);
        chkeq("R1", "mem_req after reset", mem_req, 0);

        // R1/R3: first read misses, critical word 3 first, then wraps
        run("R3", 0, 32'h0000_010C, 0, 1);
        // R2: hits in the same line
        run("R2", 0, 32'h0000_010C, 0, 1);
        run("R2", 0, 32'h0000_0104, 0, 1);
        // R4: write hit, then read back from cache
        run("R4", 1, 32'h0000_0108, 32'hCAFE_0001, 1);
        run("R4", 0, 32'h0000_0108, 0, 1);
        // R4: write miss allocates nothing
        run("R4", 1, 32'h0000_5104, 32'hBEEF_0002, 1);
        run("R4", 0, 32'h0000_5104, 0, 1);
        // R7: replacement sequence on set 0x10
        run("R7", 0, 32'h0000_0100, 0, 1);
        run("R7", 0, 32'h0000_9100, 0, 1);
        run("R7", 0, 32'h0000_5100, 0, 1);
        run("R7", 0, 32'h0000_0100, 0, 1);
        run("R7", 0, 32'h0000_9100, 0, 1);
        // R5: bypass bit
        run("R5", 0, 32'h0400_0204, 0, 1);
        run("R5", 0, 32'h0400_0204, 0, 1);
        // R8: flush set, then forge a valid entry
        tag_write(8'h10, 1'b0, 32'h0000_0000);
        run("R8", 0, 32'h0000_9100, 0, 1);
        tag_write(8'h30, 1'b1, 32'hC000_0007);
        run("R8", 0, 32'h0000_7300, 0, 0);
        // R6: lookups off
        cache_en = 1'b0;
        run("R6", 0, 32'h0000_9100, 0, 1);
        run("R6", 0, 32'h0000_9100, 0, 1);
        cache_en = 1'b1;

        // R9/R10: half cache, half SRAM
        cache_mode = 2'b01;
        clear_tags();
        run("R10", 1, 32'h1000_0040, 32'h5A5A_0040, 1);
        run("R10", 0, 32'h1000_0040, 0, 1);
        run("R9", 0, 32'h0000_0204, 0, 1);
        run("R9", 0, 32'h0000_1204, 0, 1);
        run("R9", 0, 32'h0000_0204, 0, 1);
        run("R9", 0, 32'h0000_0204, 0, 1);
        // R9/R10: all SRAM
        cache_mode = 2'b10;
        clear_tags();
        run("R10", 1, 32'h1000_0000, 32'h1111_0000, 1);
        run("R10", 1, 32'h1000_1000, 32'h2222_1000, 1);
        run("R10", 0, 32'h1000_0000, 0, 1);
        run("R10", 0, 32'h1000_1000, 0, 1);
        run("R9", 0, 32'h0000_0204, 0, 1);
        run("R9", 0, 32'h0000_0204, 0, 1);

        // random mix in full cache mode (R2 R3 R4 R5 R7 R11)
        cache_mode = 2'b00;
        clear_tags();
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic [7:0]  s;
            logic [14:0] tg;
            logic we;
            case ($urandom_range(0, 2)) 0: s = 8'h10; 1: s = 8'h11; default: s = 8'h3F; endcase
            case ($urandom_range(0, 3)) 0: tg = 15'd0; 1: tg = 15'd1; 2: tg = 15'd2; default: tg = 15'd5; endcase
            a = {5'd0, ($urandom_range(0, 7) == 0), tg[13:0], s, 2'($urandom_range(0, 3)), 2'b00};
            we = ($urandom_range(0, 2) == 0);
            run("R7", we, a, $urandom, 1);
        end

        summary();
    end
endmodule